// File: doc/BRIEF.md
# Two-Bit-Opcode Bit-Serial Processor Core

This block is a tiny processor core whose instructions carry no operands. Each instruction word is two bits wide. The data memory holds single bits. The core keeps two pieces of state outside memory: a data pointer that selects the current data bit, and a program counter that selects the current instruction. It writes its own pointer and jump target one bit at a time, into a pair of registers mapped into the top of the data memory. An arm instruction then moves the pointer literal into the pointer and clears the literal. A conditional branch falls through when the current bit is 1 and otherwise jumps to the mapped target.

The core retires one instruction per clock. Instruction fetch and data reads are combinational, and writes take effect at the clock edge. Both memories sit inside the block. While the `run` input is low, the core holds still and the memories accept loads through a simple write port. A flat image of the whole data memory is driven on an output so that the contents can be observed.

Top module: `bitcore_top`

## Requirements
- R1: Opcode 2'b00 (set) writes 1 to the data bit addressed by the pointer, then increments both the pointer and the program counter.
- R2: Opcode 2'b01 (clear) writes 0 to the data bit addressed by the pointer, then increments both the pointer and the program counter.
- R3: Opcode 2'b10 (arm) loads the pointer from the pointer literal, clears every literal bit to 0 and increments the program counter.
- R4: Opcode 2'b11 (branch) increments the program counter and leaves the pointer unchanged when the data bit at the pointer is 1.
- R5: Opcode 2'b11 (branch) loads the program counter from the jump target and leaves the pointer unchanged when the data bit at the pointer is 0.
- R6: The pointer literal occupies data addresses 2^PTR_W-PTR_W up to 2^PTR_W-1. The jump target occupies the PC_W addresses just below the literal. In both registers bit 0 is at the lowest address, and set or clear to those addresses updates the register.
- R7: The pointer and the program counter wrap to 0 when they are incremented past their maximum values.
- R8: While `rst` is high at a clock edge, the pointer and the program counter clear to 0. Memory contents are kept.
- R9: While `run` is low, the pointer and the program counter hold their values and host loads are written. While `run` is high, host loads are ignored.
- R10: The core executes exactly one instruction per clock while `run` is high. Bit i of `dm_image` is the data bit at address i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of pointer and program counter |
| run | input | 1 | High: execute one instruction per clock; low: hold and accept loads |
| pm_we | input | 1 | Host write strobe for program memory |
| pm_addr | input | PC_W | Host program memory address |
| pm_op | input | 2 | Host opcode to store |
| dm_we | input | 1 | Host write strobe for data memory |
| dm_addr | input | PTR_W | Host data memory address |
| dm_val | input | 1 | Host data bit to store |
| pc_o | output | PC_W | Current program counter |
| ptr_o | output | PTR_W | Current data pointer |
| dm_image | output | 2^PTR_W | Whole data memory, bit i at address i |

## Verification
The hardest situation to reach is a program that builds its own pointer and jump target through the mapped bits and then uses them. Set and clear must walk the pointer into the literal field, and the pointer must wrap past the top of the data space. An arm must then consume the literal, and a branch must later fall through on a 1 and jump on a 0 to a target that was written in memory. The bench preloads the literal so that the first arm lands the pointer on the literal field. The program then writes a new literal bit by bit, wraps the pointer, arms again, and runs both branch outcomes. A reference model runs in lockstep alongside and compares the pointer, the program counter and the whole memory image every cycle.

// File: rtl/bitcore_pkg.sv
package bitcore_pkg;

    typedef enum logic [1:0] {
        OP_SET = 2'b00,
        OP_CLR = 2'b01,
        OP_ARM = 2'b10,
        OP_BRC = 2'b11
    } op_e;

    typedef struct packed {
        logic wr_en;     // write a data bit at the pointer
        logic wr_val;    // value written
        logic ptr_step;  // pointer + 1
        logic ptr_load;  // pointer <= literal
        logic lit_clr;   // literal <= 0
        logic pc_jump;   // pc <= target instead of pc + 1
    } ctl_t;

    function automatic ctl_t decode_op(op_e op, logic bit_at_ptr);
        ctl_t c;
        c = '0;
        case (op)
            OP_SET: begin
                c.wr_en    = 1'b1;
                c.wr_val   = 1'b1;
                c.ptr_step = 1'b1;
            end
            OP_CLR: begin
                c.wr_en    = 1'b1;
                c.wr_val   = 1'b0;
                c.ptr_step = 1'b1;
            end
            OP_ARM: begin
                c.ptr_load = 1'b1;
                c.lit_clr  = 1'b1;
            end
            default: begin
                c.pc_jump = ~bit_at_ptr;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bitcore_opmem.sv
module bitcore_opmem #(
    parameter int PC_W = 6
) (
    input  logic            clk,
    input  logic            host_en,
    input  logic            host_we,
    input  logic [PC_W-1:0] host_addr,
    input  logic [1:0]      host_op,
    input  logic [PC_W-1:0] rd_addr,
    output logic [1:0]      rd_op
);
    localparam int DEPTH = 1 << PC_W;

    logic [1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (host_en && host_we) begin
            mem[host_addr] <= host_op;
        end
    end

    assign rd_op = mem[rd_addr];

endmodule

// File: rtl/bitcore_bitmem.sv
module bitcore_bitmem #(
    parameter int PTR_W = 6,
    parameter int PC_W  = 6
) (
    input  logic                   clk,
    input  logic                   host_en,
    input  logic                   host_we,
    input  logic [PTR_W-1:0]       host_addr,
    input  logic                   host_val,
    input  logic                   core_we,
    input  logic                   core_val,
    input  logic                   lit_clr,
    input  logic [PTR_W-1:0]       ptr,
    output logic                   bit_at_ptr,
    output logic [PTR_W-1:0]       lit,
    output logic [PC_W-1:0]        tgt,
    output logic [(1<<PTR_W)-1:0]  image
);
    localparam int DEPTH    = 1 << PTR_W;
    localparam int LIT_BASE = DEPTH - PTR_W;
    localparam int TGT_BASE = LIT_BASE - PC_W;

    logic [DEPTH-1:0] store;

    always_ff @(posedge clk) begin
        if (host_en) begin
            if (host_we) begin
                store[host_addr] <= host_val;
            end
        end else begin
            if (core_we) begin
                store[ptr] <= core_val;
            end
            if (lit_clr) begin
                store[DEPTH-1 -: PTR_W] <= '0;
            end
        end
    end

    // Mapped special registers, bit 0 at lowest address
    for (genvar i = 0; i < PTR_W; i++) begin : g_lit
        assign lit[i] = store[LIT_BASE + i];
    end
    for (genvar j = 0; j < PC_W; j++) begin : g_tgt
        assign tgt[j] = store[TGT_BASE + j];
    end

    assign bit_at_ptr = store[ptr];
    assign image      = store;

endmodule

// File: rtl/bitcore_step.sv
module bitcore_step
    import bitcore_pkg::*;
#(
    parameter int PTR_W = 6,
    parameter int PC_W  = 6
) (
    input  op_e              op,
    input  logic             bit_at_ptr,
    input  logic [PC_W-1:0]  pc,
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] lit,
    input  logic [PC_W-1:0]  tgt,
    output ctl_t             ctl,
    output logic [PC_W-1:0]  nxt_pc,
    output logic [PTR_W-1:0] nxt_ptr
);
    always_comb begin
        ctl = decode_op(op, bit_at_ptr);
        if (ctl.ptr_load) begin
            nxt_ptr = lit;
        end else if (ctl.ptr_step) begin
            nxt_ptr = PTR_W'(ptr + 1'b1);
        end else begin
            nxt_ptr = ptr;
        end
        nxt_pc = ctl.pc_jump ? tgt : PC_W'(pc + 1'b1);
    end

endmodule

// File: rtl/bitcore_top.sv
module bitcore_top
    import bitcore_pkg::*;
#(
    parameter int PTR_W = 6,
    parameter int PC_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  pm_we,
    input  logic [PC_W-1:0]       pm_addr,
    input  logic [1:0]            pm_op,
    input  logic                  dm_we,
    input  logic [PTR_W-1:0]      dm_addr,
    input  logic                  dm_val,
    output logic [PC_W-1:0]       pc_o,
    output logic [PTR_W-1:0]      ptr_o,
    output logic [(1<<PTR_W)-1:0] dm_image
);
    logic [PC_W-1:0]  pc_q, pc_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [1:0]       raw_op;
    op_e              cur_op;
    logic             cur_bit;
    logic [PTR_W-1:0] lit;
    logic [PC_W-1:0]  tgt;
    ctl_t             ctl;
    logic             core_en;

    assign core_en = run && !rst;
    assign cur_op  = op_e'(raw_op);

    bitcore_opmem #(.PC_W(PC_W)) u_opmem (
        .clk       (clk),
        .host_en   (!run),
        .host_we   (pm_we),
        .host_addr (pm_addr),
        .host_op   (pm_op),
        .rd_addr   (pc_q),
        .rd_op     (raw_op)
    );

    bitcore_bitmem #(.PTR_W(PTR_W), .PC_W(PC_W)) u_bitmem (
        .clk        (clk),
        .host_en    (!run),
        .host_we    (dm_we),
        .host_addr  (dm_addr),
        .host_val   (dm_val),
        .core_we    (core_en && ctl.wr_en),
        .core_val   (ctl.wr_val),
        .lit_clr    (core_en && ctl.lit_clr),
        .ptr        (ptr_q),
        .bit_at_ptr (cur_bit),
        .lit        (lit),
        .tgt        (tgt),
        .image      (dm_image)
    );

    bitcore_step #(.PTR_W(PTR_W), .PC_W(PC_W)) u_step (
        .op         (cur_op),
        .bit_at_ptr (cur_bit),
        .pc         (pc_q),
        .ptr        (ptr_q),
        .lit        (lit),
        .tgt        (tgt),
        .ctl        (ctl),
        .nxt_pc     (pc_d),
        .nxt_ptr    (ptr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ptr_q <= '0;
        end else if (run) begin
            pc_q  <= pc_d;
            ptr_q <= ptr_d;
        end
    end

    assign pc_o  = pc_q;
    assign ptr_o = ptr_q;

endmodule

// File: rtl/bitcore_chk.sv
module bitcore_chk #(
    parameter int PTR_W = 6,
    parameter int PC_W  = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  run,
    input logic [1:0]            op,
    input logic [PC_W-1:0]       pc_o,
    input logic [PTR_W-1:0]      ptr_o,
    input logic [(1<<PTR_W)-1:0] dm_image
);
    localparam int DEPTH    = 1 << PTR_W;
    localparam int TGT_BASE = DEPTH - PTR_W - PC_W;

    logic [PTR_W-1:0] lit_v;
    logic [PC_W-1:0]  tgt_v;
    assign lit_v = dm_image[DEPTH-1 -: PTR_W];
    assign tgt_v = dm_image[TGT_BASE + PC_W - 1 -: PC_W];

    a_r1_set: assert property (@(posedge clk) disable iff (rst)
        (run && op == 2'b00) |=> (dm_image[$past(ptr_o)] == 1'b1
            && ptr_o == PTR_W'($past(ptr_o) + 1'b1)
            && pc_o == PC_W'($past(pc_o) + 1'b1)));

    a_r2_clear: assert property (@(posedge clk) disable iff (rst)
        (run && op == 2'b01) |=> (dm_image[$past(ptr_o)] == 1'b0
            && ptr_o == PTR_W'($past(ptr_o) + 1'b1)
            && pc_o == PC_W'($past(pc_o) + 1'b1)));

    a_r3_arm: assert property (@(posedge clk) disable iff (rst)
        (run && op == 2'b10) |=> (ptr_o == $past(lit_v) && lit_v == '0
            && pc_o == PC_W'($past(pc_o) + 1'b1)));

    a_r4_branch_fall: assert property (@(posedge clk) disable iff (rst)
        (run && op == 2'b11 && dm_image[ptr_o]) |=>
            (pc_o == PC_W'($past(pc_o) + 1'b1) && $stable(ptr_o)));

    a_r5_branch_jump: assert property (@(posedge clk) disable iff (rst)
        (run && op == 2'b11 && !dm_image[ptr_o]) |=>
            (pc_o == $past(tgt_v) && $stable(ptr_o)));

    a_r8_reset: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && ptr_o == '0));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(pc_o) && $stable(ptr_o)));

endmodule

bind bitcore_top bitcore_chk #(.PTR_W(PTR_W), .PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .op       (cur_op),
    .pc_o     (pc_o),
    .ptr_o    (ptr_o),
    .dm_image (dm_image)
);

// File: tb/bitcore_top_test.sv
module bitcore_top_test;
    localparam int PW    = 6;
    localparam int CW    = 6;
    localparam int DEPTH = 1 << PW;
    localparam int LB    = DEPTH - PW;   // literal base (58)
    localparam int TB    = LB - CW;      // target base (52)

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic pm_we = 1'b0;
    logic [CW-1:0] pm_addr = '0;
    logic [1:0] pm_op = '0;
    logic dm_we = 1'b0;
    logic [PW-1:0] dm_addr = '0;
    logic dm_val = 1'b0;
    logic [CW-1:0] pc_o;
    logic [PW-1:0] ptr_o;
    logic [DEPTH-1:0] dm_image;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    logic [1:0]       m_pm [DEPTH];
    logic [DEPTH-1:0] m_dm;
    logic [CW-1:0]    m_pc;
    logic [PW-1:0]    m_ptr;

    bitcore_top #(.PTR_W(PW), .PC_W(CW)) uut (
        .clk(clk), .rst(rst), .run(run),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_op(pm_op),
        .dm_we(dm_we), .dm_addr(dm_addr), .dm_val(dm_val),
        .pc_o(pc_o), .ptr_o(ptr_o), .dm_image(dm_image)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        case (m_pm[m_pc])
            2'b00: begin m_dm[m_ptr] = 1'b1; m_ptr = m_ptr + 1'b1; m_pc = m_pc + 1'b1; end
            2'b01: begin m_dm[m_ptr] = 1'b0; m_ptr = m_ptr + 1'b1; m_pc = m_pc + 1'b1; end
            2'b10: begin m_ptr = m_dm[DEPTH-1 -: PW]; m_dm[DEPTH-1 -: PW] = '0; m_pc = m_pc + 1'b1; end
            default: begin
                if (m_dm[m_ptr]) m_pc = m_pc + 1'b1;
                else m_pc = m_dm[TB + CW - 1 -: CW];
            end
        endcase
    endtask

    task automatic put_op(input int a, input logic [1:0] op);
        @(negedge clk);
        pm_we = 1'b1; pm_addr = CW'(a); pm_op = op;
        @(negedge clk);
        pm_we = 1'b0;
        m_pm[a] = op;
    endtask

    task automatic put_bit(input int a, input logic v);
        @(negedge clk);
        dm_we = 1'b1; dm_addr = PW'(a); dm_val = v;
        @(negedge clk);
        dm_we = 1'b0;
        m_dm[a] = v;
    endtask

    task automatic wipe(input logic [1:0] op, input logic [DEPTH-1:0] img);
        for (int i = 0; i < DEPTH; i++) put_op(i, op);
        for (int i = 0; i < DEPTH; i++) put_bit(i, img[i]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = '0; m_ptr = '0;
    endtask

    // R10 lockstep: one instruction per clock, full image compared
    task automatic step_run(input int n);
        @(negedge clk);
        run = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            model_step();
            chk("R10 lockstep pc", 64'(pc_o), 64'(m_pc));
            chk("R10 lockstep ptr", 64'(ptr_o), 64'(m_ptr));
            chk("R10 lockstep image", dm_image, m_dm);
        end
        run = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R8 reset pc", 64'(pc_o), 64'd0);
        chk("R8 reset ptr", 64'(ptr_o), 64'd0);
    endtask

    // R1 and R7: all-set program walks and wraps pointer and pc
    task automatic t_set_wrap();
        wipe(2'b00, '0);
        do_reset();
        step_run(70);
        chk("R7 pc wrap", 64'(pc_o), 64'd6);
        chk("R7 ptr wrap", 64'(ptr_o), 64'd6);
        chk("R1 set fills memory", dm_image, {64{1'b1}});
    endtask

    // R2: all-clear program over a full memory
    task automatic t_clear();
        wipe(2'b01, {64{1'b1}});
        do_reset();
        step_run(10);
        chk("R2 clear low bits", dm_image, ~64'h3FF);
        chk("R2 ptr advanced", 64'(ptr_o), 64'd10);
    endtask

    // R3, R6, R7, R4, R5: self-built pointer, arm, both branch outcomes
    task automatic t_build_and_branch();
        wipe(2'b11, '0);
        put_op(0, 2'b10);
        put_op(1, 2'b00); put_op(2, 2'b01); put_op(3, 2'b00);
        put_op(4, 2'b01); put_op(5, 2'b01); put_op(6, 2'b01);
        put_op(7, 2'b10);
        put_op(8, 2'b11); put_op(9, 2'b01); put_op(10, 2'b11);
        put_op(40, 2'b00);
        // literal = 58 (bit 0 at address 58)
        put_bit(LB+0, 1'b0); put_bit(LB+1, 1'b1); put_bit(LB+2, 1'b0);
        put_bit(LB+3, 1'b1); put_bit(LB+4, 1'b1); put_bit(LB+5, 1'b1);
        // target = 40
        put_bit(TB+3, 1'b1); put_bit(TB+5, 1'b1);
        put_bit(5, 1'b1);
        do_reset();
        step_run(1);
        chk("R3 arm loads literal", 64'(ptr_o), 64'd58);
        chk("R3 arm clears literal", 64'(dm_image[DEPTH-1 -: PW]), 64'd0);
        step_run(6);
        chk("R6 literal written bitwise", 64'(dm_image[DEPTH-1 -: PW]), 64'd5);
        chk("R7 ptr wraps past top", 64'(ptr_o), 64'd0);
        step_run(1);
        chk("R6 arm uses written literal", 64'(ptr_o), 64'd5);
        step_run(1);
        chk("R4 branch falls through", 64'(pc_o), 64'd9);
        chk("R4 ptr unchanged", 64'(ptr_o), 64'd5);
        step_run(2);
        chk("R5 branch jumps to target", 64'(pc_o), 64'd40);
        chk("R5 ptr unchanged", 64'(ptr_o), 64'd6);
        step_run(4);
    endtask

    // R9: hold while idle, host loads ignored while running
    task automatic t_hold_ignore();
        logic [CW-1:0] pc0;
        logic [PW-1:0] ptr0;
        wipe(2'b11, '0);
        do_reset();
        step_run(3);
        pc0 = pc_o; ptr0 = ptr_o;
        repeat (5) @(negedge clk);
        chk("R9 idle pc hold", 64'(pc_o), 64'(pc0));
        chk("R9 idle ptr hold", 64'(ptr_o), 64'(ptr0));
        @(negedge clk);
        run = 1'b1;
        dm_we = 1'b1; dm_addr = PW'(20); dm_val = 1'b1;
        pm_we = 1'b1; pm_addr = '0; pm_op = 2'b00;
        repeat (3) @(negedge clk);
        dm_we = 1'b0; pm_we = 1'b0;
        repeat (2) @(negedge clk);
        run = 1'b0;
        chk("R9 host data load ignored", 64'(dm_image[20]), 64'd0);
        chk("R9 host program load ignored", 64'(pc_o), 64'd0);
        chk("R9 image untouched", dm_image, 64'd0);
    endtask

    // R8: reset mid-program keeps memory
    task automatic t_reset_keeps();
        logic [DEPTH-1:0] img;
        wipe(2'b00, '0);
        do_reset();
        step_run(9);
        img = dm_image;
        do_reset();
        @(negedge clk);
        chk("R8 reset pc mid-run", 64'(pc_o), 64'd0);
        chk("R8 reset ptr mid-run", 64'(ptr_o), 64'd0);
        chk("R8 memory kept", dm_image, img);
        chk("R8 memory content", dm_image, 64'h1FF);
    endtask

    initial begin
        m_dm = '0; m_pc = '0; m_ptr = '0;
        for (int i = 0; i < DEPTH; i++) m_pm[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set_wrap();
        t_clear();
        t_build_and_branch();
        t_hold_ignore();
        t_reset_keeps();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule